// File: doc/BRIEF.md
# Embedded-Audio Extractor Status Registers

This block is the byte-wide register bank of the audio extraction path in a serial digital video receiver. The datapath sends it single-cycle error pulses for ancillary checksum, three parity checks, channel-status CRC and audio packet ECRC. It also sends the FIFO fill level and fault pulse, the decoded rate-field bits, the control-packet presence flag, the clock-rate flag, the PLL offset and channel-status bytes. Software reads and clears this state through a plain address/read/write/data port.

Errors are tallied in a 4-bit saturating counter and latched in per-cause sticky flags. Both are cleared by writing ones. The FIFO fault flag starts out set after reset, so software clears it once before it means anything. Channel-status bytes for the two audio channels are stored as the datapath delivers them and are read back through a 48-byte window. Read data is registered and returned one cycle after the read strobe.

Top module: `aud_stat_regs`

## Requirements
- R1: The error status register (address 02h) holds a counter in bits 3:0. The counter rises by one in each cycle in which at least one error input pulses, and it holds at 15.
- R2: A write to address 02h with any of data bits 3:0 set clears the whole counter to zero.
- R3: Bits 4, 5, 6 and 7 of address 02h are sticky flags for checksum, parity, channel-status CRC and packet ECRC errors. Each flag stays set until software writes 1 to that bit, and writing 0 leaves it unchanged.
- R4: The parity flag (bit 5) is set by an error on any of the ancillary parity, audio sample parity or AES sample parity inputs.
- R5: When a clear and an error event happen in the same cycle, the event wins. The flag stays set and the counter ends at 1.
- R6: The FIFO register (address 03h) shows the live fill level in bits 6:0 and a sticky fault flag in bit 7. The fault flag is 1 after reset, is set by a fault pulse, is cleared by writing 1 to bit 7, and a fault pulse wins over a clear in the same cycle.
- R7: The rate register (address 01h) shows the asynchronous bit in bit 4, the two rate-code bits in bits 6:5 and control-packet presence in bit 7. Bits 3:0 read 0.
- R8: The clock register (address 04h) shows the PLL offset in bits 4:0 and the fractional-rate flag in bit 7. Bits 6:5 read 0, and writes to it have no effect.
- R9: Channel-status bytes written by the datapath (channel 0 index 0..23 or channel 1 index 0..23) read back at 10h+index and 28h+index. Indexes of 24 and above are dropped, and software writes to 10h..3Fh have no effect.
- R10: Read data appears on the cycle after the read strobe and holds until the next read. It is 0 after reset, and reads of addresses 00h and 05h..0Fh return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 6 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| cs_err_i | input | 1 | Ancillary checksum error pulse |
| par_anc_err_i | input | 1 | Ancillary packet parity error pulse |
| par_smp_err_i | input | 1 | Audio sample parity error pulse |
| par_aes_err_i | input | 1 | AES sample parity error pulse |
| crc_err_i | input | 1 | Channel-status CRC error pulse |
| ecrc_err_i | input | 1 | Audio packet ECRC error pulse |
| fifo_level_i | input | 7 | FIFO fill level |
| fifo_fault_i | input | 1 | FIFO overflow/underflow pulse |
| rate_async_i | input | 1 | Asynchronous bit from the rate field |
| rate_code_i | input | 2 | Sample-rate code bits |
| ctl_pkt_i | input | 1 | Control packet present |
| clk_frac_i | input | 1 | Video clock at the 1/1.001 rate |
| pll_offset_i | input | 5 | PLL offset status |
| cs_we_i | input | 1 | Channel-status byte write |
| cs_chan_i | input | 1 | Channel-status channel select |
| cs_idx_i | input | 5 | Channel-status byte index |
| cs_data_i | input | 8 | Channel-status byte |

## Verification
Every piece of state in this block reaches software only through a read, so a corrupted counter, flag or stored byte stays hidden until that address is read. It then appears exactly one cycle after the read strobe. For that reason the bench reads often and compares the registered read data on every cycle against a behavioural model. Any wrong counter step, lost event, missed clear or misplaced channel-status byte then shows up at the first read of the affected address. Directed phases put saturation, a clear and an event in the same cycle, the reset value of the FIFO flag and out-of-range indexes where such a read exposes them.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 4;
  localparam int LVL_W    = 7;
  localparam int OFS_W    = 5;
  localparam int N_ERR    = 4;
  localparam int CS_BYTES = 24;
  localparam int CS_CHANS = 2;
  localparam int CS_DEPTH = CS_BYTES * CS_CHANS;

  localparam logic [ADDR_W-1:0] A_RATE = 6'h01;
  localparam logic [ADDR_W-1:0] A_ERR  = 6'h02;
  localparam logic [ADDR_W-1:0] A_FIFO = 6'h03;
  localparam logic [ADDR_W-1:0] A_CLK  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CS   = 6'h10;

  typedef enum logic [1:0] {
    E_CSUM = 2'd0,
    E_PAR  = 2'd1,
    E_CRC  = 2'd2,
    E_ECRC = 2'd3
  } err_e;
endpackage

// File: rtl/aud_sticky.sv
module aud_sticky #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= RST_VAL;
    else if (set_i) q <= 1'b1;  // event beats clear
    else if (clr_i) q <= 1'b0;
  end
  assign q_o = q;
endmodule

// File: rtl/aud_err_cnt.sv
module aud_err_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q, base;

  always_comb begin
    base = clr_i ? '0 : cnt_q;
    if (inc_i && base != MAX) base = base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= base;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/aud_cs_store.sv
module aud_cs_store #(
  parameter int BYTES = 24,
  parameter int CHANS = 2,
  parameter int DW    = 8,
  localparam int DEPTH = BYTES * CHANS,
  localparam int IW    = $clog2(DEPTH),
  localparam int BW    = $clog2(BYTES),
  localparam int CW    = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] chan_i,
  input  logic [BW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_ok;
  int            wr_pos;

  assign wr_ok  = we_i && (int'(idx_i) < BYTES) && (int'(chan_i) < CHANS);
  assign wr_pos = int'(chan_i) * BYTES + int'(idx_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mem_q[g] <= '0;
      else if (wr_ok && wr_pos == g) mem_q[g] <= data_i;
    end
  end

  assign rd_data_o = (int'(rd_idx_i) < DEPTH) ? mem_q[rd_idx_i] : '0;
endmodule

// File: rtl/aud_stat_regs.sv
module aud_stat_regs
  import aud_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cs_err_i,
  input  logic              par_anc_err_i,
  input  logic              par_smp_err_i,
  input  logic              par_aes_err_i,
  input  logic              crc_err_i,
  input  logic              ecrc_err_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              fifo_fault_i,
  input  logic              rate_async_i,
  input  logic [1:0]        rate_code_i,
  input  logic              ctl_pkt_i,
  input  logic              clk_frac_i,
  input  logic [OFS_W-1:0]  pll_offset_i,
  input  logic              cs_we_i,
  input  logic              cs_chan_i,
  input  logic [4:0]        cs_idx_i,
  input  logic [DATA_W-1:0] cs_data_i
);
  localparam int IW = $clog2(CS_DEPTH);

  logic [N_ERR-1:0]  err_evt, err_flg;
  logic [CNT_W-1:0]  err_cnt;
  logic              any_err, fifo_flg;
  logic              wr_err, wr_fifo, in_cs;
  logic [ADDR_W-1:0] cs_off;
  logic [DATA_W-1:0] cs_rd, rd_mux, rdata_q;

  assign err_evt[E_CSUM] = cs_err_i;
  assign err_evt[E_PAR]  = par_anc_err_i | par_smp_err_i | par_aes_err_i;
  assign err_evt[E_CRC]  = crc_err_i;
  assign err_evt[E_ECRC] = ecrc_err_i;
  assign any_err         = |err_evt;

  assign wr_err  = reg_wr_i && reg_addr_i == A_ERR;
  assign wr_fifo = reg_wr_i && reg_addr_i == A_FIFO;

  aud_err_cnt #(.W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .clr_i (wr_err && |reg_wdata_i[CNT_W-1:0]),
    .inc_i (any_err),
    .cnt_o (err_cnt)
  );

  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    aud_sticky #(.RST_VAL(1'b0)) i_flag (
      .clk_i, .rst_ni,
      .set_i (err_evt[i]),
      .clr_i (wr_err && reg_wdata_i[CNT_W+i]),
      .q_o   (err_flg[i])
    );
  end

  // fault flag comes up set until software acknowledges it
  aud_sticky #(.RST_VAL(1'b1)) i_fifo_flag (
    .clk_i, .rst_ni,
    .set_i (fifo_fault_i),
    .clr_i (wr_fifo && reg_wdata_i[DATA_W-1]),
    .q_o   (fifo_flg)
  );

  assign in_cs  = int'(reg_addr_i) >= int'(A_CS) && int'(reg_addr_i) < int'(A_CS) + CS_DEPTH;
  assign cs_off = reg_addr_i - A_CS;

  aud_cs_store #(.BYTES(CS_BYTES), .CHANS(CS_CHANS), .DW(DATA_W)) i_cs (
    .clk_i, .rst_ni,
    .we_i      (cs_we_i),
    .chan_i    (cs_chan_i),
    .idx_i     (cs_idx_i),
    .data_i    (cs_data_i),
    .rd_idx_i  (cs_off[IW-1:0]),
    .rd_data_o (cs_rd)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_RATE:  rd_mux = {ctl_pkt_i, rate_code_i, rate_async_i, 4'b0000};
      A_ERR:   rd_mux = {err_flg, err_cnt};
      A_FIFO:  rd_mux = {fifo_flg, fifo_level_i};
      A_CLK:   rd_mux = {clk_frac_i, 2'b00, pll_offset_i};
      default: rd_mux = in_cs ? cs_rd : '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/aud_stat_chk.sv
module aud_stat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       any_err,
  input logic [3:0] err_cnt,
  input logic [3:0] err_flg,
  input logic       fifo_fault_i,
  input logic       fifo_flg
);
  logic clr_cnt, unmapped;
  assign clr_cnt  = reg_wr_i && reg_addr_i == 6'h02 && reg_wdata_i[3:0] != 4'h0;
  assign unmapped = reg_addr_i == 6'h00 || (reg_addr_i > 6'h04 && reg_addr_i < 6'h10);

  a_r1_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt == 4'hF && !clr_cnt) |=> err_cnt == 4'hF);
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_cnt && any_err && err_cnt != 4'hF) |=> err_cnt == $past(err_cnt) + 4'h1);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cnt && !any_err) |=> err_cnt == 4'h0);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flg[0] && !(reg_wr_i && reg_addr_i == 6'h02 && reg_wdata_i[4])) |=> err_flg[0]);
  a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cnt && any_err) |=> err_cnt == 4'h1);
  a_r6_fault_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_fault_i |=> fifo_flg);
  a_r10_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && unmapped) |=> reg_rdata_o == 8'h00);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

bind aud_stat_regs aud_stat_chk i_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
  .any_err, .err_cnt, .err_flg, .fifo_fault_i, .fifo_flg
);

// File: tb/test_aud_stat_regs.sv
module test_aud_stat_regs;
  localparam logic [5:0] RATE = 6'h01, ERR = 6'h02, FIFO = 6'h03, CLK = 6'h04;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] reg_addr_i = '0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic cs_err_i = 0, par_anc_err_i = 0, par_smp_err_i = 0, par_aes_err_i = 0;
  logic crc_err_i = 0, ecrc_err_i = 0, fifo_fault_i = 0;
  logic [6:0] fifo_level_i = '0;
  logic rate_async_i = 0, ctl_pkt_i = 0, clk_frac_i = 0;
  logic [1:0] rate_code_i = '0;
  logic [4:0] pll_offset_i = '0, cs_idx_i = '0;
  logic cs_we_i = 0, cs_chan_i = 0;
  logic [7:0] cs_data_i = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  aud_stat_regs i_aud_stat_regs (.*);

  int compared = 0, mismatched = 0;
  string phase = "R10";

  // reference state
  int        m_cnt;
  bit [3:0]  m_flg;
  bit        m_ff;
  bit [7:0]  m_cs [48];
  bit [7:0]  m_rd;

  function automatic bit [7:0] m_read(input logic [5:0] a);
    case (a)
      RATE: return {ctl_pkt_i, rate_code_i, rate_async_i, 4'h0};
      ERR:  return {m_flg, 4'(m_cnt)};
      FIFO: return {m_ff, fifo_level_i};
      CLK:  return {clk_frac_i, 2'b00, pll_offset_i};
      default: return (a >= 6'h10) ? m_cs[int'(a) - 16] : 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_flg = '0; m_ff = 1'b1; m_rd = '0;
    foreach (m_cs[i]) m_cs[i] = '0;
  endtask

  task automatic m_step();
    bit [7:0] nrd;
    bit [3:0] ev;
    nrd = reg_rd_i ? m_read(reg_addr_i) : m_rd;
    if (reg_wr_i && reg_addr_i == ERR) begin
      if (reg_wdata_i[3:0] != 0) m_cnt = 0;
      m_flg &= ~reg_wdata_i[7:4];
    end
    if (reg_wr_i && reg_addr_i == FIFO && reg_wdata_i[7]) m_ff = 1'b0;
    ev = {ecrc_err_i, crc_err_i, par_anc_err_i | par_smp_err_i | par_aes_err_i, cs_err_i};
    if (ev != 0 && m_cnt < 15) m_cnt++;
    m_flg |= ev;
    if (fifo_fault_i) m_ff = 1'b1;
    if (cs_we_i && cs_idx_i < 24) m_cs[(cs_chan_i ? 24 : 0) + int'(cs_idx_i)] = cs_data_i;
    m_rd = nrd;
  endtask

  task automatic compare();
    compared++;
    if (reg_rdata_o !== m_rd) begin
      mismatched++;
      $display("FAIL %s addr=%02h rdata actual=%02h expected=%02h at %0t",
               phase, reg_addr_i, reg_rdata_o, m_rd, $time);
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [5:0] a, input logic [7:0] d);
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    m_step();
    @(negedge clk_i);
    compare();
    reg_wr_i = 0; reg_rd_i = 0;
    {cs_err_i, par_anc_err_i, par_smp_err_i, par_aes_err_i, crc_err_i, ecrc_err_i} = '0;
    fifo_fault_i = 0; cs_we_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare();  // R10: zero after reset

    // R6: flag set after reset, then acknowledged
    phase = "R6";
    fifo_level_i = 7'h2A;
    cyc(0, 1, FIFO, 8'h00);
    cyc(1, 0, FIFO, 8'h80);
    cyc(0, 1, FIFO, 8'h00);
    fifo_fault_i = 1; cyc(0, 0, FIFO, 0);
    cyc(0, 1, FIFO, 0);
    fifo_fault_i = 1; cyc(1, 0, FIFO, 8'h80);  // fault wins
    cyc(0, 1, FIFO, 0);
    cyc(1, 0, FIFO, 8'h7F);                     // level bits read-only
    fifo_level_i = 7'h05; cyc(0, 1, FIFO, 0);

    // R1: saturation
    phase = "R1";
    for (int i = 0; i < 20; i++) begin
      cs_err_i = 1; crc_err_i = (i % 3 == 0);
      cyc(0, 1, ERR, 0);
    end
    cyc(0, 1, ERR, 0);

    // R3: per-flag clear
    phase = "R3";
    ecrc_err_i = 1; par_aes_err_i = 1; cyc(0, 0, ERR, 0);
    cyc(1, 0, ERR, 8'h00); cyc(0, 1, ERR, 0);
    for (int b = 4; b < 8; b++) begin
      cyc(1, 0, ERR, 8'(1 << b));
      cyc(0, 1, ERR, 0);
    end

    // R2: counter clear, each low bit
    phase = "R2";
    for (int b = 0; b < 4; b++) begin
      cs_err_i = 1; cyc(0, 0, ERR, 0);
      cyc(1, 1, ERR, 8'(1 << b));
      cyc(0, 1, ERR, 0);
    end
    cyc(1, 0, ERR, 8'hF0); cyc(0, 1, ERR, 0);

    // R4: each parity source alone
    phase = "R4";
    par_anc_err_i = 1; cyc(0, 0, ERR, 0); cyc(0, 1, ERR, 0); cyc(1, 0, ERR, 8'hFF);
    par_smp_err_i = 1; cyc(0, 0, ERR, 0); cyc(0, 1, ERR, 0); cyc(1, 0, ERR, 8'hFF);
    par_aes_err_i = 1; cyc(0, 0, ERR, 0); cyc(0, 1, ERR, 0); cyc(1, 0, ERR, 8'hFF);

    // R5: clear and event together
    phase = "R5";
    cs_err_i = 1; cyc(0, 0, ERR, 0); cs_err_i = 1; cyc(0, 0, ERR, 0);
    ecrc_err_i = 1; cyc(1, 0, ERR, 8'hFF);
    cyc(0, 1, ERR, 0);

    // R7, R8: live fields and ignored writes
    for (int i = 0; i < 16; i++) begin
      rate_async_i = 1'($urandom); rate_code_i = 2'($urandom); ctl_pkt_i = 1'($urandom);
      clk_frac_i = 1'($urandom); pll_offset_i = 5'($urandom);
      phase = "R7"; cyc(1, 1, RATE, 8'($urandom));
      phase = "R8"; cyc(1, 1, CLK, 8'($urandom));
      cyc(0, 1, CLK, 0);
    end

    // R9: channel-status window
    phase = "R9";
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 32; i++) begin
        cs_we_i = 1; cs_chan_i = 1'(c); cs_idx_i = 5'(i); cs_data_i = 8'($urandom);
        cyc(0, 0, 6'h10, 0);
      end
    for (int a = 16; a < 64; a++) begin
      cyc(1, 0, 6'(a), 8'hA5);
      cyc(0, 1, 6'(a), 0);
    end

    // R10: unmapped reads, hold behaviour
    phase = "R10";
    cyc(0, 1, RATE, 0);
    cyc(0, 1, 6'h00, 0);
    for (int a = 5; a < 16; a++) begin
      cyc(0, 1, ERR, 0);
      cyc(1, 1, 6'(a), 8'hFF);
      cyc(0, 0, 6'(a), 0);
    end

    // mixed random traffic
    phase = "R1";
    for (int i = 0; i < 3000; i++) begin
      cs_err_i = ($urandom % 8 == 0); par_anc_err_i = ($urandom % 16 == 0);
      par_smp_err_i = ($urandom % 16 == 0); par_aes_err_i = ($urandom % 16 == 0);
      crc_err_i = ($urandom % 12 == 0); ecrc_err_i = ($urandom % 12 == 0);
      fifo_fault_i = ($urandom % 20 == 0); fifo_level_i = 7'($urandom);
      rate_async_i = 1'($urandom); rate_code_i = 2'($urandom); ctl_pkt_i = 1'($urandom);
      clk_frac_i = 1'($urandom); pll_offset_i = 5'($urandom);
      cs_we_i = 1'($urandom); cs_chan_i = 1'($urandom); cs_idx_i = 5'($urandom);
      cs_data_i = 8'($urandom);
      cyc(($urandom % 4 == 0), ($urandom % 2 == 0),
          ($urandom % 2 == 0) ? 6'($urandom % 5) : 6'($urandom), 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule